// File: doc/BRIEF.md
# Start-Triggered Step Sequencer

A small control sequencer for a datapath that needs one setup step followed by a fixed number of work steps. The sequencer is built around a 3-bit down counter, and each count value is decoded into its own one-hot step strobe. A rising edge on the start input loads the counter with 5, which is the setup step. On each later clock the counter steps down through the work steps 4, 3, 2 and 1. It then reaches 0, the idle step, and stays there.

The clock to the counter is never gated. When the sequencer is idle, the counter's own value is routed back into its flip-flops, so the count holds. The next value is chosen by a fixed priority: a start edge while idle loads 5; otherwise an idle counter holds; otherwise the count goes down by one. A new run begins only after start has been low and then high again, so a start line that stays high produces exactly one run. Reset only sets the power-up state.

Top module: `step_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, state_o is 000 and done_o is 1. If start_i is already high when reset is released, no run begins.
- R2: While idle, a cycle in which start_i is high after being low in the previous cycle loads state_o with 101 at the next clock edge.
- R3: While state_o is not 000, it decreases by exactly one at every clock edge.
- R4: When state_o is 000 and no start edge is seen, it stays at 000. It never wraps to 111, and it never takes the value 110 or 111.
- R5: If start_i stays high across the end of a run, the sequencer stays idle. A new run needs start_i to go low and then high again.
- R6: A start rising edge that arrives while a run is in progress is ignored, and the countdown continues without change.
- R7: step_o is one-hot: bit k is 1 exactly when state_o equals k, where bit 0 is the idle step and bit 5 is the setup step.
- R8: busy_o is 1 for states 101 through 001, and done_o is 1 exactly in state 000.
- R9: A run takes exactly six clock edges, counted from the edge that loads 101 up to and including the edge that reaches 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; it always runs |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Run request; acts on its rising edge |
| state_o | output | 3 | Current step number |
| step_o | output | 8 | One-hot decode of the step number |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Idle step |

## Verification
The start input is driven in four ways. A clean pulse checks loading and the full countdown. A level that stays high checks that the sequencer does not retrigger. A second pulse in the middle of a run checks that the edge is ignored while busy. A level that is already high when reset is released checks that reset alone never launches a run. Two more patterns round this out: long idle gaps confirm that the counter holds at zero without wrapping, and back-to-back pulses timed just after done confirm that a run can start again straight away.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  parameter int CNT_W   = 3;
  parameter int STEPS   = 1 << CNT_W;
  parameter logic [CNT_W-1:0] LOAD_VAL = 3'd5;
  parameter logic [CNT_W-1:0] IDLE_VAL = 3'd0;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [STEPS-1:0] dec_t;

  // Priority: load, then hold at idle, then decrement.
  function automatic cnt_t next_count(input cnt_t cur, input logic load);
    if (load)
      return LOAD_VAL;
    else if (cur == IDLE_VAL)
      return cur;
    else
      return cur - cnt_t'(1);
  endfunction

  function automatic dec_t one_hot(input cnt_t v);
    dec_t d;
    d = '0;
    d[v] = 1'b1;
    return d;
  endfunction
endpackage

// File: rtl/start_edge.sv
module start_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b1;
    else       prev_q <= start_i;
  end

  assign rise_o = start_i & ~prev_q;

  // A level that is held high never produces a second edge.
  assert_no_retrigger_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && $past(start_i)) |-> !rise_o);
endmodule

// File: rtl/step_counter.sv
module step_counter
  import step_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic rise_i,
  output cnt_t cnt_o,
  output logic load_o
);
  cnt_t cnt_q;
  cnt_t cnt_d;
  logic idle;

  assign idle   = (cnt_q == IDLE_VAL);
  assign load_o = rise_i & idle;
  assign cnt_d  = next_count(cnt_q, load_o);

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= IDLE_VAL;
    else       cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |=> (cnt_o == LOAD_VAL));
  assert_countdown_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_o != IDLE_VAL) |=> (cnt_o == $past(cnt_o) - cnt_t'(1)));
  assert_hold_idle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_o == IDLE_VAL && !load_o) |=> (cnt_o == IDLE_VAL));
  assert_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_o <= LOAD_VAL);
  assert_ignore_busy_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_i && cnt_o != IDLE_VAL) |=> (cnt_o != LOAD_VAL));
endmodule

// File: rtl/step_decoder.sv
module step_decoder
  import step_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  cnt_t cnt_i,
  output dec_t dec_o
);
  for (genvar k = 0; k < STEPS; k++) begin : g_dec
    assign dec_o[k] = (cnt_i == cnt_t'(k));
  end

  assert_onehot_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(dec_o) == 1);
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import step_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       start_i,
  output logic [2:0] state_o,
  output logic [7:0] step_o,
  output logic       busy_o,
  output logic       done_o
);
  logic start_rise;
  logic load_evt;
  cnt_t cnt;
  dec_t dec;

  start_edge u_edge (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .start_i(start_i),
    .rise_o (start_rise)
  );

  step_counter u_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .rise_i(start_rise),
    .cnt_o (cnt),
    .load_o(load_evt)
  );

  step_decoder u_dec (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .cnt_i(cnt),
    .dec_o(dec)
  );

  assign state_o = cnt;
  assign step_o  = dec;
  assign done_o  = dec[0];
  assign busy_o  = ~dec[0];

  assert_flags_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o != done_o) && (done_o == (state_o == 3'd0)));
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (state_o == 3'd0));
endmodule

// File: tb/step_sequencer_bench.sv
module step_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [2:0] state;
  logic [7:0] step;
  logic       busy;
  logic       done;

  int vectors = 0;
  int fails   = 0;

  int m_state;
  bit m_prev;

  always #4 clk = ~clk;

  step_sequencer u_step_sequencer (
    .clk_i  (clk),
    .rst_i  (rst),
    .start_i(start),
    .state_o(state),
    .step_o (step),
    .busy_o (busy),
    .done_o (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, update the model at the edge, compare after.
  task automatic cyc(input bit r, input bit s, input string req);
    bit rise;
    start = s;
    rst   = r;
    @(posedge clk);
    if (r) begin
      m_state = 0;
      m_prev  = 1;
    end else begin
      rise = s && !m_prev;
      if (rise && m_state == 0) m_state = 5;
      else if (m_state != 0)    m_state = m_state - 1;
      m_prev = s;
    end
    @(negedge clk);
    chk({req, " state"}, int'(state), m_state);
    chk("R7 step", int'(step), 1 << m_state);
    chk("R8 busy", int'(busy), int'(m_state != 0));
    chk("R8 done", int'(done), int'(m_state == 0));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int len;
    m_state = 0;
    m_prev  = 1;
    rst = 1; start = 0;
    @(negedge clk);
    // R1: reset state, start held high across reset release
    cyc(1, 1, "R1");
    cyc(1, 1, "R1");
    chk("R1 reset state", int'(state), 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, "R1");
    chk("R1 no launch", int'(state), 0);
    // R2/R3/R9: clean pulse, count the run length
    cyc(0, 0, "R2");
    cyc(0, 1, "R2");
    chk("R2 loaded", int'(state), 5);
    len = 1;
    while (state != 0 && len < 20) begin
      cyc(0, 1, "R3");
      len++;
    end
    chk("R9 run length", len, 6);
    // R5: start still high, no retrigger; R4 hold without wrap
    for (int i = 0; i < 6; i++) cyc(0, 1, "R5");
    chk("R5 still idle", int'(state), 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, "R4");
    chk("R4 no wrap", int'(state), 0);
    // R6: second edge mid-run ignored
    cyc(0, 1, "R2");
    cyc(0, 0, "R6");
    cyc(0, 1, "R6");
    chk("R6 ignored", int'(state), 3);
    for (int i = 0; i < 4; i++) cyc(0, 0, "R6");
    chk("R6 finished", int'(state), 0);
    // back-to-back runs: edge right after done
    for (int r = 0; r < 3; r++) begin
      cyc(0, 1, "R2");
      for (int i = 0; i < 5; i++) cyc(0, (i % 2), "R3");
      cyc(0, 0, "R4");
    end
    // mixed pattern with a mid-run reset
    for (int i = 0; i < 40; i++) cyc((i == 17), ((i * 7) % 5) > 2, "R3");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule